// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block manages thirteen general-purpose pins behind a byte-wide register port. Each pin owns a pad-control byte and a sense byte. The pad-control byte sets the direction, whether the pin drives push-pull or open-drain, the pull resistor and the output level. The sense byte returns the synchronized pin level and selects which transitions count as events.

Pin events are latched in status bits that are cleared by writing 1. The status and mask bits are packed into two uneven groups of seven and six bits. A single registered interrupt line stays high while any status bit is set whose mask bit is clear.

Software writes the pad and sense bytes to configure a pin, clears mask bits to enable its interrupt, then services the interrupt by reading the status groups and writing 1 to each handled bit. Transitions that arrive while software is servicing the interrupt set their status bits again.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: Pad-control bytes sit at 0x4E44+p and sense bytes at 0x4E51+p for pin p = 0..12. Status groups sit at 0x4E0B/0x4E0C and mask groups at 0x4E19/0x4E1A. Any other address reads 0x00, and writes to it change no register.
- R2: Pad-control byte layout: bit 5 = drive enable (1 = output), bit 4 = push-pull (0 = open-drain), bit 3 = pull enable, bits 2:1 = pull select, bit 0 = output level. Bits 7:6 read as 0.
- R3: With bit 5 = 0 the pin is neither driven nor output high. In push-pull mode pin_oe = 1 and pin_out equals the level. In open-drain mode pin_out = 0 and pin_oe is the inverse of the level.
- R4: pull_en follows bit 3. pull_up follows bit 1 (codes 01 and 11 pull up). pull_weak follows bit 2 (codes 10 and 11 select the weak resistor).
- R5: Sense byte bit 0 reads the pin level through a two-flop synchronizer, so a change is visible after the second rising clock edge. Bits 2:1 read back the event select, bits 7:3 read as 0, and writes to bit 0 have no effect.
- R6: Event select codes: 00 = none, 01 = falling, 10 = rising, 11 = both. A qualifying pin change sets its status bit on the third rising clock edge after the change.
- R7: Pins 0..6 map to bits 6:0 of the first status and mask groups. Pins 7..12 map to bits 5:0 of the second groups. Unused upper bits read 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: When an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: Status latches whatever the mask. irq is high in a cycle exactly when some status bit was set with its mask bit clear in the previous cycle.
- R11: Reset clears all pad-control bytes, all event selects, all status bits and irq, and sets every mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 13 | Raw pin levels |
| pin_out | output | 13 | Output value per pin |
| pin_oe | output | 13 | Output enable per pin |
| pull_en | output | 13 | Pull resistor enable |
| pull_up | output | 13 | Pull direction, 1 = up |
| pull_weak | output | 13 | Pull strength, 1 = weak |
| irq | output | 1 | Interrupt request |

## Verification
A status bit set without an event, or one cleared by a write of 0, shows on the status read port at once. One cycle later irq also goes wrong if that pin is unmasked. A wrong pad-control bit reaches the pad outputs in the same cycle as the faulty write. A synchronizer that is one stage short or long shifts both the sense-byte level and the cycle in which status sets by one cycle. The bench compares every port on every cycle against a cycle-accurate model, so such a fault is reported on the first cycle it appears.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // Field order follows the pad-control byte, bit 5 down to bit 0.
  typedef struct packed {
    logic dir_out;
    logic push_pull;
    logic pull_en;
    logic pull_weak;
    logic pull_up;
    logic level;
  } pad_cfg_t;

  function automatic logic edge_seen(edge_sel_e sel, logic now_lvl, logic old_lvl);
    logic r;
    unique case (sel)
      EDGE_FALL: r = old_lvl & ~now_lvl;
      EDGE_RISE: r = ~old_lvl & now_lvl;
      EDGE_ANY:  r = old_lvl ^ now_lvl;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_prev
);

  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl      = sync_q;
  assign lvl_prev = prev_q;

endmodule

// File: rtl/gpio_pad_cfg.sv
module gpio_pad_cfg
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS-1:0]          cfg_we,
  input  logic [NUM_PINS-1:0]          sel_we,
  input  logic [7:0]                   wdata,
  output pad_cfg_t  [NUM_PINS-1:0]     cfg_q,
  output edge_sel_e [NUM_PINS-1:0]     sel_q,
  output logic [NUM_PINS-1:0]          pin_out,
  output logic [NUM_PINS-1:0]          pin_oe,
  output logic [NUM_PINS-1:0]          pull_en,
  output logic [NUM_PINS-1:0]          pull_up,
  output logic [NUM_PINS-1:0]          pull_weak
);

  localparam int CFG_W = $bits(pad_cfg_t);

  pad_cfg_t  [NUM_PINS-1:0] cfg_d;
  edge_sel_e [NUM_PINS-1:0] sel_d;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      cfg_d[i] = cfg_we[i] ? pad_cfg_t'(wdata[CFG_W-1:0]) : cfg_q[i];
      sel_d[i] = sel_we[i] ? edge_sel_e'(wdata[2:1]) : sel_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        cfg_q[i] <= '0;
        sel_q[i] <= EDGE_OFF;
      end
    end else begin
      cfg_q <= cfg_d;
      sel_q <= sel_d;
    end
  end

  // Pad drive: open-drain only pulls low, push-pull drives both ways.
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      pin_oe[i]    = cfg_q[i].dir_out & (cfg_q[i].push_pull | ~cfg_q[i].level);
      pin_out[i]   = cfg_q[i].dir_out & cfg_q[i].push_pull & cfg_q[i].level;
      pull_en[i]   = cfg_q[i].pull_en;
      pull_up[i]   = cfg_q[i].pull_up;
      pull_weak[i] = cfg_q[i].pull_weak;
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_PINS-1:0]      lvl,
  input  logic [NUM_PINS-1:0]      lvl_prev,
  input  edge_sel_e [NUM_PINS-1:0] sel_q,
  input  logic [NUM_PINS-1:0]      clr,
  input  logic [NUM_PINS-1:0]      mask_we,
  input  logic [NUM_PINS-1:0]      mask_wdata,
  output logic [NUM_PINS-1:0]      status_q,
  output logic [NUM_PINS-1:0]      mask_q,
  output logic [NUM_PINS-1:0]      hit,
  output logic                     irq
);

  logic [NUM_PINS-1:0] status_d, mask_d;
  logic                irq_d, irq_q;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      hit[i] = edge_seen(sel_q[i], lvl[i], lvl_prev[i]);
    end
    // A fresh event outranks a clear of the same bit.
    status_d = (status_q & ~clr) | hit;
    mask_d   = (mask_q & ~mask_we) | (mask_wdata & mask_we);
    irq_d    = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int          NUM_PINS  = 13,
  parameter int          GRP0_PINS = 7,
  parameter int          ADDR_W    = 16,
  parameter int unsigned OUT_BASE  = 32'h4E44,
  parameter int unsigned IN_BASE   = 32'h4E51,
  parameter int unsigned STAT_BASE = 32'h4E0B,
  parameter int unsigned MASK_BASE = 32'h4E19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [NUM_PINS-1:0] pull_weak,
  output logic                irq
);

  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;

  logic [NUM_PINS-1:0]      lvl, lvl_prev;
  logic [NUM_PINS-1:0]      cfg_we, sel_we, clr_vec, mask_we, mask_wdata;
  logic [NUM_PINS-1:0]      st_vec, mk_vec, hit_vec;
  pad_cfg_t  [NUM_PINS-1:0] cfg_q;
  edge_sel_e [NUM_PINS-1:0] sel_q;
  logic [7:0]               st_g0, st_g1, mk_g0, mk_g1;

  gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_async(pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  gpio_pad_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .sel_we   (sel_we),
    .wdata    (reg_wdata),
    .cfg_q    (cfg_q),
    .sel_q    (sel_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pull_en  (pull_en),
    .pull_up  (pull_up),
    .pull_weak(pull_weak)
  );

  gpio_irq_unit #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (lvl),
    .lvl_prev  (lvl_prev),
    .sel_q     (sel_q),
    .clr       (clr_vec),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .status_q  (st_vec),
    .mask_q    (mk_vec),
    .hit       (hit_vec),
    .irq       (irq)
  );

  // Per-pin write decode and group bit placement.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int GRP = (i < GRP0_PINS) ? 0 : 1;
    localparam int BIT = (i < GRP0_PINS) ? i : i - GRP0_PINS;

    assign cfg_we[i]     = reg_wr && (reg_addr == ADDR_W'(OUT_BASE + i));
    assign sel_we[i]     = reg_wr && (reg_addr == ADDR_W'(IN_BASE + i));
    assign clr_vec[i]    = reg_wr && (reg_addr == ADDR_W'(STAT_BASE + GRP)) && reg_wdata[BIT];
    assign mask_we[i]    = reg_wr && (reg_addr == ADDR_W'(MASK_BASE + GRP));
    assign mask_wdata[i] = reg_wdata[BIT];

    if (GRP == 0) begin : g_grp0
      assign st_g0[BIT] = st_vec[i];
      assign mk_g0[BIT] = mk_vec[i];
    end else begin : g_grp1
      assign st_g1[BIT] = st_vec[i];
      assign mk_g1[BIT] = mk_vec[i];
    end
  end

  if (GRP0_PINS < 8) begin : g_pad0
    assign st_g0[7:GRP0_PINS] = '0;
    assign mk_g0[7:GRP0_PINS] = '0;
  end
  if (GRP1_PINS < 8) begin : g_pad1
    assign st_g1[7:GRP1_PINS] = '0;
    assign mk_g1[7:GRP1_PINS] = '0;
  end

  // Read mux: unmapped addresses fall through to zero.
  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (reg_addr == ADDR_W'(OUT_BASE + i)) reg_rdata = {2'b00, cfg_q[i]};
      if (reg_addr == ADDR_W'(IN_BASE + i))  reg_rdata = {5'b00000, sel_q[i], lvl[i]};
    end
    if (reg_addr == ADDR_W'(STAT_BASE))     reg_rdata = st_g0;
    if (reg_addr == ADDR_W'(STAT_BASE + 1)) reg_rdata = st_g1;
    if (reg_addr == ADDR_W'(MASK_BASE))     reg_rdata = mk_g0;
    if (reg_addr == ADDR_W'(MASK_BASE + 1)) reg_rdata = mk_g1;
  end

endmodule

// File: rtl/gpio_edge_irq_ctrl_chk.sv
module gpio_edge_irq_ctrl_chk #(
  parameter int          NUM_PINS  = 13,
  parameter int          ADDR_W    = 16,
  parameter int unsigned OUT_BASE  = 32'h4E44,
  parameter int unsigned IN_BASE   = 32'h4E51,
  parameter int unsigned STAT_BASE = 32'h4E0B,
  parameter int unsigned MASK_BASE = 32'h4E19
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [7:0]          reg_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] st_vec,
  input logic [NUM_PINS-1:0] mk_vec,
  input logic [NUM_PINS-1:0] hit_vec,
  input logic [NUM_PINS-1:0] clr_vec
);

  logic        mapped;
  int unsigned a;

  always_comb begin
    a      = 32'(reg_addr);
    mapped = (a >= OUT_BASE && a < OUT_BASE + NUM_PINS) ||
             (a >= IN_BASE  && a < IN_BASE + NUM_PINS)  ||
             a == STAT_BASE || a == STAT_BASE + 1 ||
             a == MASK_BASE || a == MASK_BASE + 1;
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == 8'h00); // R1

  AST_HIGH_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R3

  AST_STATUS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vec & ~$past(st_vec) & ~$past(hit_vec)) == '0); // R6

  AST_CLEAR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_vec & ~hit_vec) & st_vec) == '0); // R8

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_vec & hit_vec) & ~st_vec) == '0); // R9

  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|$past(st_vec & ~mk_vec))); // R10

endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .OUT_BASE (OUT_BASE),
  .IN_BASE  (IN_BASE),
  .STAT_BASE(STAT_BASE),
  .MASK_BASE(MASK_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq      (irq),
  .st_vec   (st_vec),
  .mk_vec   (mk_vec),
  .hit_vec  (hit_vec),
  .clr_vec  (clr_vec)
);

// File: tb/gpio_edge_irq_ctrl_test.sv
module gpio_edge_irq_ctrl_test;

  localparam int N    = 13;
  localparam int G0   = 7;
  localparam int OUTB = 'h4E44;
  localparam int INB  = 'h4E51;
  localparam int STB  = 'h4E0B;
  localparam int MKB  = 'h4E19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr;
  logic [7:0]  wdata;
  logic [N-1:0] pins;
  wire  [7:0]  rdata;
  wire  [N-1:0] pout, poe, pen, pup, pweak;
  wire         irq;

  always #5 clk = ~clk;

  gpio_edge_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe),
    .pull_en(pen), .pull_up(pup), .pull_weak(pweak), .irq(irq)
  );

  // Reference state built from the requirements.
  logic [5:0]   m_cfg [N];
  logic [1:0]   m_sel [N];
  logic [N-1:0] m_st, m_mask, s1, s2, s3, m_hit, m_clr;
  logic         m_irq;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_sel[i] = '0; end
      m_st = '0; m_mask = '1; s1 = '0; s2 = '0; s3 = '0; m_irq = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        case (m_sel[i])
          2'b01:   m_hit[i] = s3[i] & ~s2[i];
          2'b10:   m_hit[i] = ~s3[i] & s2[i];
          2'b11:   m_hit[i] = s3[i] ^ s2[i];
          default: m_hit[i] = 1'b0;
        endcase
      end
      m_irq = |(m_st & ~m_mask);
      m_clr = '0;
      if (wr) begin
        for (int i = 0; i < N; i++) begin
          if (int'(addr) == OUTB + i) m_cfg[i] = wdata[5:0];
          if (int'(addr) == INB + i)  m_sel[i] = wdata[2:1];
        end
        if (int'(addr) == STB)     m_clr[G0-1:0] = wdata[G0-1:0];
        if (int'(addr) == STB + 1) m_clr[N-1:G0] = wdata[N-G0-1:0];
        if (int'(addr) == MKB)     m_mask[G0-1:0] = wdata[G0-1:0];
        if (int'(addr) == MKB + 1) m_mask[N-1:G0] = wdata[N-G0-1:0];
      end
      m_st = (m_st & ~m_clr) | m_hit;
      s3 = s2; s2 = s1; s1 = pins;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < N; i++) begin
      if (int'(a) == OUTB + i) r = {2'b00, m_cfg[i]};
      if (int'(a) == INB + i)  r = {5'b00000, m_sel[i], s2[i]};
    end
    if (int'(a) == STB)     r = {1'b0, m_st[G0-1:0]};
    if (int'(a) == STB + 1) r = {2'b00, m_st[N-1:G0]};
    if (int'(a) == MKB)     r = {1'b0, m_mask[G0-1:0]};
    if (int'(a) == MKB + 1) r = {2'b00, m_mask[N-1:G0]};
    return r;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (int'(a) >= OUTB && int'(a) < OUTB + N) return "R2";
    if (int'(a) >= INB && int'(a) < INB + N)   return "R5";
    if (int'(a) == STB || int'(a) == STB + 1 || int'(a) == MKB || int'(a) == MKB + 1) return "R7";
    return "R1";
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [N-1:0] e_oe, e_out;
    for (int i = 0; i < N; i++) begin
      e_oe[i]  = m_cfg[i][5] & (m_cfg[i][4] | ~m_cfg[i][0]);
      e_out[i] = m_cfg[i][5] & m_cfg[i][4] & m_cfg[i][0];
    end
    chk("R3", "pin_oe", 32'(poe), 32'(e_oe));
    chk("R3", "pin_out", 32'(pout), 32'(e_out));
    for (int i = 0; i < N; i++) begin
      chk("R4", "pull_en", 32'(pen[i]), 32'(m_cfg[i][3]));
      chk("R4", "pull_up", 32'(pup[i]), 32'(m_cfg[i][1]));
      chk("R4", "pull_weak", 32'(pweak[i]), 32'(m_cfg[i][2]));
    end
    chk("R10", "irq", 32'(irq), 32'(m_irq));
    chk(tag_of(addr), "rdata", 32'(rdata), 32'(exp_rd(addr)));
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    addr = 16'(a); wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string tag, input logic [7:0] exp);
    addr = 16'(a);
    step();
    chk(tag, "directed read", 32'(rdata), 32'(exp));
  endtask

  initial begin
    #(10ns * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; addr = '0; wr = 1'b0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    for (int i = 0; i < N; i++) rd_chk(OUTB + i, "R11", 8'h00);
    for (int i = 0; i < N; i++) rd_chk(INB + i, "R11", 8'h00);
    rd_chk(STB, "R11", 8'h00);
    rd_chk(STB + 1, "R11", 8'h00);
    rd_chk(MKB, "R11", 8'h7F);
    rd_chk(MKB + 1, "R11", 8'h3F);
    chk("R11", "irq after reset", 32'(irq), 32'd0);
    chk("R11", "pin_oe after reset", 32'(poe), 32'd0);

    // R1: unmapped addresses
    wr_reg('h4E5E, 8'hFF);
    wr_reg('h4E43, 8'hFF);
    wr_reg('h4E0D, 8'hFF);
    wr_reg('h4E1B, 8'hFF);
    rd_chk('h4E5E, "R1", 8'h00);
    rd_chk('h4E43, "R1", 8'h00);
    rd_chk(OUTB + 12, "R1", 8'h00);
    rd_chk(MKB + 1, "R1", 8'h3F);

    // R2: pad-control byte
    wr_reg(OUTB + 7, 8'hFF);
    rd_chk(OUTB + 7, "R2", 8'h3F);

    // R3: drive modes on pin 2
    wr_reg(OUTB + 2, 8'h31); chk("R3", "push-pull high oe", 32'(poe[2]), 32'd1);
    chk("R3", "push-pull high out", 32'(pout[2]), 32'd1);
    wr_reg(OUTB + 2, 8'h21); chk("R3", "open-drain released", 32'(poe[2]), 32'd0);
    wr_reg(OUTB + 2, 8'h20); chk("R3", "open-drain low", 32'(poe[2]), 32'd1);
    chk("R3", "open-drain out", 32'(pout[2]), 32'd0);
    wr_reg(OUTB + 2, 8'h11); chk("R3", "input dir", 32'(poe[2]), 32'd0);

    // R4: pull controls on pin 5
    wr_reg(OUTB + 5, 8'h0E);
    chk("R4", "weak up en", 32'({pen[5], pweak[5], pup[5]}), 32'h7);
    wr_reg(OUTB + 5, 8'h04);
    chk("R4", "weak down off", 32'({pen[5], pweak[5], pup[5]}), 32'h2);

    // R5: sense byte and synchronizer latency
    wr_reg(INB, 8'hFF);
    rd_chk(INB, "R5", 8'h06);
    pins[0] = 1'b1; addr = 16'(INB);
    step(); chk("R5", "level after one edge", 32'(rdata), 32'h06);
    step(); chk("R5", "level after two edges", 32'(rdata), 32'h07);
    step(); step();
    wr_reg(STB, 8'h01);

    // R6: falling-only on pin 4
    wr_reg(INB + 4, 8'h02);
    pins[4] = 1'b1; step(); step(); step();
    rd_chk(STB, "R6", 8'h00);
    pins[4] = 1'b0; step(); step(); step();
    rd_chk(STB, "R6", 8'h10);
    wr_reg(STB, 8'h10);
    rd_chk(STB, "R8", 8'h00);
    wr_reg(STB, 8'h00);

    // R9 / R10: both edges on pin 9 (group 1 bit 2)
    wr_reg(INB + 9, 8'h06);
    wr_reg(MKB + 1, 8'h3B);
    pins[9] = 1'b1; step(); step(); step();
    rd_chk(STB + 1, "R6", 8'h04);
    chk("R10", "irq raised", 32'(irq), 32'd1);
    pins[9] = 1'b0; step(); step();
    wr_reg(STB + 1, 8'h04);
    rd_chk(STB + 1, "R9", 8'h04);
    wr_reg(STB + 1, 8'h04);
    rd_chk(STB + 1, "R8", 8'h00);
    chk("R10", "irq dropped", 32'(irq), 32'd0);
    wr_reg(MKB + 1, 8'h3F);
    pins[9] = 1'b1; step(); step(); step(); step();
    rd_chk(STB + 1, "R10", 8'h04);
    chk("R10", "masked irq", 32'(irq), 32'd0);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 3 == 0) pins = pins ^ N'(1 << ($urandom % N));
      case ($urandom % 6)
        0: addr = 16'(OUTB + int'($urandom % N));
        1: addr = 16'(INB + int'($urandom % N));
        2: addr = 16'(STB + int'($urandom % 2));
        3: addr = 16'(MKB + int'($urandom % 2));
        4: addr = 16'('h4E00 + int'($urandom % 128));
        default: addr = 16'($urandom);
      endcase
      wr = ($urandom % 3 == 0);
      wdata = 8'($urandom);
      step();
    end
    wr = 1'b0;
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule